// File: doc/BRIEF.md
# Split-Capable Down-Counting Timer

This block is a down-counting timer that works either as one wide counter or as two independent half-width counters, called A and B. A three-bit layout input chooses between the two forms. In the split layout, each half has its own four-bit mode word, load value, match value, enable, edge select, output polarity and capture pin. Each half can then act as a one-shot timer, a periodic timer, a counter of pin edges, a timestamper of pin edges, or a pulse-width modulator.

The block is driven by a static configuration. The control word places each half's enable, edge select and output-invert bits at fixed positions. Time-outs and capture events appear as one-cycle pulses. The current count, the last captured count and the modulated outputs are always visible at the ports.

Top module: `gp_timer`

## Requirements
- R1: While reset is asserted, both counts, both capture values, all event pulses and both modulated outputs are 0 (the layout input is 0 during reset).
- R2: A layout value of 4 splits the counter. Any other value forms one counter of twice the half width: `{cnt_b,cnt_a}` loads from `{load_b,load_a}`, half A's enable and mode apply (mode 1 one-shot, anything else periodic), time-outs appear on `to_a`, and `to_b`, `ev_b`, `pwm_a` and `pwm_b` stay low.
- R3: In the split layout, a half whose enable is low, or whose mode bits [1:0] are 0 with mode bit 3 clear, holds its count at its load value.
- R4: Mode bits [1:0] = 1 select one-shot. The count drops by one each clock. The clock that finds it at 0 pulses the time-out, and the count then stays halted until the half's enable has been low for at least one clock.
- R5: Mode bits [1:0] = 2 select periodic. The clock that finds the count at 0 pulses the time-out and reloads, giving a period of load+1 clocks.
- R6: The edge select for A is control bits [3:2] and for B is bits [11:10]. The values are 00 rising, 01 falling and 11 both; 10 reacts to no edge. Each pin passes through two synchronizing flops, so a pin change takes effect at the third rising clock edge after it.
- R7: Mode bits [1:0] = 3 with mode bit 2 clear count edges. Each selected edge lowers the count by one. An edge that finds the count at 0 reloads it and pulses the event output.
- R8: Mode bits [1:0] = 3 with mode bit 2 set timestamp edges. The count runs as in R5, and each selected edge copies the current count into the capture output and pulses the event output.
- R9: Mode bit 3 selects PWM, whatever bits [2:0] hold. The count runs as in R5, and the output is high while the count exceeds the match value, inverted when the invert bit is set (control bit 6 for A, bit 14 for B).
- R10: The enable for A is control bit 0 and for B is bit 8. In the split layout each half behaves only according to its own inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg | input | 3 | Layout: 4 split, otherwise wide |
| mode_a | input | 4 | Half A: [1:0] kind, [2] timestamp, [3] PWM |
| mode_b | input | 4 | Half B mode word, same encoding |
| ctl | input | 16 | Enables, edge selects, invert bits |
| load_a | input | HW | Half A reload value |
| load_b | input | HW | Half B reload value |
| match_a | input | HW | Half A PWM match value |
| match_b | input | HW | Half B PWM match value |
| pin_a | input | 1 | Half A capture pin |
| pin_b | input | 1 | Half B capture pin |
| cnt_a | output | HW | Half A count |
| cnt_b | output | HW | Half B count |
| cap_a | output | HW | Half A captured count |
| cap_b | output | HW | Half B captured count |
| to_a | output | 1 | Half A time-out pulse |
| to_b | output | 1 | Half B time-out pulse |
| ev_a | output | 1 | Half A capture event pulse |
| ev_b | output | 1 | Half B capture event pulse |
| pwm_a | output | 1 | Half A modulated output |
| pwm_b | output | 1 | Half B modulated output |

## Verification
The counts are outputs, so a wrong load, a missed decrement or a wrong borrow between the halves shows on `cnt_a` or `cnt_b` in the very clock it happens. A stale re-arm flag shows up later, as a one-shot half that fails to restart once its enable returns. A wrong synchronizer depth or edge decode shows as an event pulse or a capture value one clock early or late, or as one that is missing. The bench compares every output against a behavioural model at every clock, so any of these faults is seen within one cycle of reaching the ports.

// File: rtl/gp_timer.sv
module gp_timer #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cfg,
  input  logic [3:0]    mode_a,
  input  logic [3:0]    mode_b,
  input  logic [15:0]   ctl,
  input  logic [HW-1:0] load_a,
  input  logic [HW-1:0] load_b,
  input  logic [HW-1:0] match_a,
  input  logic [HW-1:0] match_b,
  input  logic          pin_a,
  input  logic          pin_b,
  output logic [HW-1:0] cnt_a,
  output logic [HW-1:0] cnt_b,
  output logic [HW-1:0] cap_a,
  output logic [HW-1:0] cap_b,
  output logic          to_a,
  output logic          to_b,
  output logic          ev_a,
  output logic          ev_b,
  output logic          pwm_a,
  output logic          pwm_b
);
  localparam int W = 2 * HW;

  logic               split;
  logic [1:0][HW-1:0] cnt, cap, ld, mt;
  logic [1:0][3:0]    md;
  logic [1:0][1:0]    esel;
  logic [1:0]         en, inv, armed, to, ev, hit, s1, s2, s3;
  logic [W-1:0]       wcnt, wld;
  logic               wrun;

  assign split = cfg == 3'd4;
  assign md    = {mode_b, mode_a};
  assign ld    = {load_b, load_a};
  assign mt    = {match_b, match_a};
  assign en    = {ctl[8], ctl[0]};
  assign inv   = {ctl[14], ctl[6]};
  assign esel  = {ctl[11:10], ctl[3:2]};
  assign wcnt  = {cnt[1], cnt[0]};
  assign wld   = {load_b, load_a};
  assign wrun  = en[0] & armed[0];

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      case (esel[i])
        2'b00:   hit[i] = s2[i] & ~s3[i];
        2'b01:   hit[i] = ~s2[i] & s3[i];
        2'b11:   hit[i] = s2[i] ^ s3[i];
        default: hit[i] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      cap   <= '0;
      armed <= '1;
      to    <= '0;
      ev    <= '0;
      s1    <= '0;
      s2    <= '0;
      s3    <= '0;
    end else begin
      s1 <= {pin_b, pin_a};
      s2 <= s1;
      s3 <= s2;
      to <= '0;
      ev <= '0;
      for (int i = 0; i < 2; i++)
        if (!en[i]) armed[i] <= 1'b1;
      if (!split) begin
        if (!wrun) {cnt[1], cnt[0]} <= wld;
        else if (wcnt == '0) begin
          to[0] <= 1'b1;
          if (md[0][1:0] == 2'd1) armed[0] <= 1'b0;
          else {cnt[1], cnt[0]} <= wld;
        end else {cnt[1], cnt[0]} <= wcnt - 1'b1;
      end else begin
        for (int i = 0; i < 2; i++) begin
          if (!(en[i] && armed[i]) || (md[i][1:0] == 2'd0 && !md[i][3]))
            cnt[i] <= ld[i];
          else if (md[i][3] || md[i][1:0] == 2'd2 || (md[i][1:0] == 2'd3 && md[i][2])) begin
            if (cnt[i] == '0) begin
              to[i]  <= 1'b1;
              cnt[i] <= ld[i];
            end else cnt[i] <= cnt[i] - 1'b1;
            if (!md[i][3] && md[i][1:0] == 2'd3 && hit[i]) begin
              cap[i] <= cnt[i];
              ev[i]  <= 1'b1;
            end
          end else if (md[i][1:0] == 2'd1) begin
            if (cnt[i] == '0) begin
              to[i]    <= 1'b1;
              armed[i] <= 1'b0;
            end else cnt[i] <= cnt[i] - 1'b1;
          end else if (hit[i]) begin
            if (cnt[i] == '0) begin
              ev[i]  <= 1'b1;
              cnt[i] <= ld[i];
            end else cnt[i] <= cnt[i] - 1'b1;
          end
        end
      end
    end
  end

  assign cnt_a = cnt[0];
  assign cnt_b = cnt[1];
  assign cap_a = cap[0];
  assign cap_b = cap[1];
  assign to_a  = to[0];
  assign to_b  = to[1];
  assign ev_a  = ev[0];
  assign ev_b  = ev[1];
  assign pwm_a = split & md[0][3] & ((cnt[0] > mt[0]) ^ inv[0]);
  assign pwm_b = split & md[1][3] & ((cnt[1] > mt[1]) ^ inv[1]);

  // R5
  periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (to_a && $past(split && md[0][1:0] == 2'd2 && !md[0][3])) |-> cnt_a == $past(load_a));

  // R4
  oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (to_b && $past(split && md[1][1:0] == 2'd1 && !md[1][3])) |-> cnt_b == '0);

  // R8
  capture_with_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_a) |-> ev_a);

  // R7
  event_needs_capture_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_b |-> $past(split && md[1][1:0] == 2'd3 && !md[1][3]));

  // R2
  wide_quiet_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!split) |-> (!to_b && !ev_b));
endmodule

// File: tb/gp_timer_tb.sv
`timescale 1ns/1ps
module gp_timer_tb;
  localparam int P = 65536;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg = 3'd0;
  logic [3:0]  mode_a = 4'd0, mode_b = 4'd0;
  logic [15:0] ctl = 16'd0;
  logic [15:0] load_a = 16'd0, load_b = 16'd0, match_a = 16'd0, match_b = 16'd0;
  logic        pin_a = 1'b0, pin_b = 1'b0;
  logic [15:0] cnt_a, cnt_b, cap_a, cap_b;
  logic        to_a, to_b, ev_a, ev_b, pwm_a, pwm_b;

  int    checks = 0;
  int    errors = 0;
  string req = "R1";

  always #2.5 clk = ~clk;

  gp_timer #(.HW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .mode_a(mode_a), .mode_b(mode_b),
    .ctl(ctl), .load_a(load_a), .load_b(load_b), .match_a(match_a),
    .match_b(match_b), .pin_a(pin_a), .pin_b(pin_b), .cnt_a(cnt_a),
    .cnt_b(cnt_b), .cap_a(cap_a), .cap_b(cap_b), .to_a(to_a), .to_b(to_b),
    .ev_a(ev_a), .ev_b(ev_b), .pwm_a(pwm_a), .pwm_b(pwm_b));

  int mc[2], mcap[2], marm[2], mto[2], mev[2];
  int q[$];

  function automatic bit edge_hit(int sel, int cur, int old);
    if (sel == 0) return cur == 1 && old == 0;
    if (sel == 1) return cur == 0 && old == 1;
    if (sel == 3) return cur != old;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mc = '{0, 0}; mcap = '{0, 0}; marm = '{1, 1}; mto = '{0, 0}; mev = '{0, 0};
      q = '{0, 0, 0};
    end else begin
      int oc[2], oa[2], m[2], ld[2], en[2], sel[2];
      longint w, wl;
      oc = mc; oa = marm;
      m = '{int'(mode_a), int'(mode_b)};
      ld = '{int'(load_a), int'(load_b)};
      en = '{int'(ctl[0]), int'(ctl[8])};
      sel = '{int'(ctl[3:2]), int'(ctl[11:10])};
      mto = '{0, 0}; mev = '{0, 0};
      for (int i = 0; i < 2; i++) if (en[i] == 0) marm[i] = 1;
      if (cfg != 3'd4) begin
        w  = longint'(oc[1]) * P + oc[0];
        wl = longint'(ld[1]) * P + ld[0];
        if (!(en[0] == 1 && oa[0] == 1)) w = wl;
        else if (w == 0) begin
          mto[0] = 1;
          if ((m[0] % 4) == 1) marm[0] = 0; else w = wl;
        end else w = w - 1;
        mc[0] = int'(w % P); mc[1] = int'(w / P);
      end else begin
        for (int i = 0; i < 2; i++) begin
          int kind, ts, alt, cur, old;
          kind = m[i] % 4; ts = (m[i] / 4) % 2; alt = m[i] / 8;
          cur = (q[1] >> i) & 1; old = (q[0] >> i) & 1;
          if (!(en[i] == 1 && oa[i] == 1) || (kind == 0 && alt == 0)) mc[i] = ld[i];
          else if (alt == 1 || kind == 2 || (kind == 3 && ts == 1)) begin
            if (oc[i] == 0) begin mto[i] = 1; mc[i] = ld[i]; end
            else mc[i] = oc[i] - 1;
            if (alt == 0 && kind == 3 && edge_hit(sel[i], cur, old)) begin
              mcap[i] = oc[i]; mev[i] = 1;
            end
          end else if (kind == 1) begin
            if (oc[i] == 0) begin mto[i] = 1; marm[i] = 0; end
            else mc[i] = oc[i] - 1;
          end else if (edge_hit(sel[i], cur, old)) begin
            if (oc[i] == 0) begin mev[i] = 1; mc[i] = ld[i]; end
            else mc[i] = oc[i] - 1;
          end
        end
      end
      q.push_back(int'(pin_a) + 2 * int'(pin_b));
      void'(q.pop_front());
    end
  end

  task automatic chk(string name, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, name, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int pa, pb;
      pa = (cfg == 3'd4 && mode_a[3]) ? ((mc[0] > int'(match_a)) ^ int'(ctl[6])) : 0;
      pb = (cfg == 3'd4 && mode_b[3]) ? ((mc[1] > int'(match_b)) ^ int'(ctl[14])) : 0;
      chk("cnt_a", cnt_a, mc[0]);   chk("cnt_b", cnt_b, mc[1]);
      chk("cap_a", cap_a, mcap[0]); chk("cap_b", cap_b, mcap[1]);
      chk("to_a", to_a, mto[0]);    chk("to_b", to_b, mto[1]);
      chk("ev_a", ev_a, mev[0]);    chk("ev_b", ev_b, mev[1]);
      chk("pwm_a", pwm_a, pa);      chk("pwm_b", pwm_b, pb);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic toggle(int which, int times, int gap);
    for (int k = 0; k < times; k++) begin
      if (which == 0) pin_a = ~pin_a; else pin_b = ~pin_b;
      step(gap);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL %s watchdog: actual=timeout expected=completion", req);
    finish_run();
  end

  initial begin
    step(2);
    @(negedge clk);
    req = "R1";
    chk("reset cnt_a", cnt_a, 0); chk("reset cnt_b", cnt_b, 0);
    chk("reset cap_a", cap_a, 0); chk("reset cap_b", cap_b, 0);
    chk("reset pulses", {to_a, to_b, ev_a, ev_b}, 0);
    chk("reset pwm", {pwm_a, pwm_b}, 0);
    step(1);
    rst_n = 1'b1;

    req = "R3";
    cfg = 3'd4; mode_a = 4'd2; mode_b = 4'd0; load_a = 16'd10; load_b = 16'd20;
    ctl[8] = 1'b1;
    step(6);
    ctl[8] = 1'b0;

    req = "R4";
    mode_a = 4'd1; load_a = 16'd5; ctl[0] = 1'b1;
    req = "R10";
    mode_b = 4'd2; load_b = 16'd3; ctl[8] = 1'b1;
    req = "R4";
    step(16);
    ctl[0] = 1'b0;
    step(2);
    ctl[0] = 1'b1;
    step(9);

    req = "R5";
    mode_a = 4'd2; load_a = 16'd4;
    step(14);
    ctl[0] = 1'b0; ctl[8] = 1'b0;
    step(1);

    req = "R2";
    cfg = 3'd0; mode_a = 4'd2; load_a = 16'd2; load_b = 16'd1; ctl[0] = 1'b1;
    step(8);
    ctl[0] = 1'b0;
    step(1);
    load_a = 16'd3; load_b = 16'd0; mode_a = 4'd1; mode_b = 4'b1010; ctl[0] = 1'b1;
    step(8);
    cfg = 3'd5; mode_a = 4'd2;
    step(6);
    ctl[0] = 1'b0;
    step(1);

    req = "R7";
    cfg = 3'd4; mode_a = 4'd3; mode_b = 4'd0; load_a = 16'd3; ctl[3:2] = 2'b00; ctl[0] = 1'b1;
    step(2);
    toggle(0, 10, 4);
    req = "R6";
    ctl[3:2] = 2'b01; toggle(0, 6, 3);
    ctl[3:2] = 2'b11; toggle(0, 6, 1);
    ctl[3:2] = 2'b10; toggle(0, 6, 3);

    req = "R8";
    mode_b = 4'b0111; load_b = 16'd40; ctl[8] = 1'b1; ctl[11:10] = 2'b00;
    step(3);
    toggle(1, 6, 5);
    ctl[11:10] = 2'b11;
    toggle(1, 6, 7);
    ctl[11:10] = 2'b01;
    toggle(1, 4, 9);
    ctl[0] = 1'b0; ctl[8] = 1'b0;
    step(1);

    req = "R9";
    mode_a = 4'b1010; load_a = 16'd9; match_a = 16'd4; ctl[6] = 1'b0; ctl[0] = 1'b1;
    mode_b = 4'b1111; load_b = 16'd6; match_b = 16'd0; ctl[14] = 1'b1; ctl[8] = 1'b1;
    step(25);
    ctl[6] = 1'b1; ctl[14] = 1'b0; match_a = 16'd9;
    step(25);
    match_a = 16'd0; match_b = 16'd6;
    step(12);
    finish_run();
  end
endmodule